// File: doc/BRIEF.md
# Punched Card Column Sequencer

The sequencer follows one card at a time as it travels past a line of twelve optical row sensors. While no card is present it waits. The first clock on which any sensor reads dark marks the card's leading edge, and that position becomes column 0. From then on, an internal divider advances the column count once every `TICK_DIV` system clocks. For each of the data columns 1 to 80, the block issues a one-clock index strobe together with the punch pattern it sampled in that column.

The block also checks the card's position at three columns:

- **Column 0 (leading margin):** every row must read dark.
- **Column 81 (trailing margin):** every row must read dark.
- **Column 84 (card gone):** every row must read lit.

If any of these checks fails, a sticky read-check flag is set. An optional mask can be applied to the trailing-margin check only. When it is on, the topmost row (row 12) is ignored there, so cards with a diagonal notch cut in the right-hand corner are accepted. All checks, and the data capture, sample the sensors once per column at a fixed phase late in the column period.

When column 84 is reached, the block raises a one-clock done pulse. It then waits for every sensor to read lit before it arms for the next card.

Top module: `card_col_seq`

## Requirements
- R1: From idle, the first clock edge that sees any `row_dark` bit high starts a card. At that edge `col_count` becomes 0 and `read_err` clears.
- R2: `col_count` increases by one every `TICK_DIV` clocks after the start and stops at 84 (`DATA_COLS`+4).
- R3: For each column 1..80, in column order, exactly one single-clock `idx_strobe` is issued, with `col_data` bit i = 1 when row sensor i read lit. Bit 11 is row 12, bit 10 is row 11, and bits 9..0 are rows 9..0. No strobe is issued at columns 0 or 81..84.
- R4: At column 0, any lit row sets `read_err`.
- R5: At column 81, any lit row sets `read_err`. This check is evaluated only once per card.
- R6: When `mask_notch` is 1, bit 11 (row 12) is treated as dark at the column-81 check only. The column-0 check and the other rows at column 81 are unaffected.
- R7: At column 84, any dark row sets `read_err`.
- R8: Sensors are sampled only at clock `SAMPLE_PH` within each column. A row that is lit only earlier in the column period has no effect.
- R9: `cycle_done` pulses for one clock when the column-84 check is made. After that, no new card starts until all rows read lit.
- R10: `read_err` stays set until the next card starts or until reset.
- R11: During and after reset, `col_count`, `idx_strobe`, `col_data`, `read_err` and `cycle_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_dark | input | ROWS | Row sensor levels, 1 = dark; bit ROWS-1 is row 12 |
| mask_notch | input | 1 | Ignore row 12 during the trailing-margin check |
| col_count | output | CW | Current column number, 0..DATA_COLS+4 |
| idx_strobe | output | 1 | One-clock strobe per data column |
| col_data | output | ROWS | Punch pattern (1 = hole) valid with `idx_strobe`, else 0 |
| read_err | output | 1 | Sticky read-check flag |
| cycle_done | output | 1 | One-clock pulse when the card-gone check is made |

## Verification
The bench builds the block with `TICK_DIV` = 8 and `SAMPLE_PH` = 6, instead of a divider worth 500 µs. This shortens a full 85-column card pass to under 700 clocks, so one run can push many cards through and exercise every margin check, the notch mask on both margins, and a reset in mid-card. Because the sample phase sits at 6 of 8, there are six clocks before it in which a brief light leak can be injected and shown to be ignored.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REARM = 2'd2
  } seq_state_t;

  // True when a column number lies inside the data field 1..data_cols.
  function automatic logic is_data_col(int unsigned col, int unsigned data_cols);
    return (col >= 1) && (col <= data_cols);
  endfunction

endpackage

// File: rtl/col_timer.sv
// Column period divider: one sample point and one advance per column.
module col_timer #(
  parameter int TICK_DIV  = 50000,
  parameter int SAMPLE_PH = 43750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic sample_pt,
  output logic col_adv
);
  localparam int PW   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int LAST = TICK_DIV - 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (restart) ph <= '0;
    else if (run)     ph <= (ph == PW'(LAST)) ? '0 : ph + 1'b1;
  end

  assign sample_pt = run && (ph == PW'(SAMPLE_PH));
  assign col_adv   = run && (ph == PW'(LAST));

  // R8: a column's sample point and its advance never coincide.
  p_sample_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> !col_adv);
endmodule

// File: rtl/margin_check.sv
// Position checks on the row sensors at the leading, trailing and exit columns.
module margin_check #(
  parameter int ROWS = 12
) (
  input  logic [ROWS-1:0] row_dark,
  input  logic            mask_top,
  input  logic            chk_lead,
  input  logic            chk_trail,
  input  logic            chk_gone,
  output logic            fail
);
  function automatic logic all_dark(logic [ROWS-1:0] v);
    return &v;
  endfunction

  logic [ROWS-1:0] trail_view;
  logic lead_fail, trail_fail, gone_fail;

  // The notch mask forces the top row to look dark, at the trailing margin only.
  assign trail_view = row_dark | {mask_top, {(ROWS-1){1'b0}}};
  assign lead_fail  = chk_lead  && !all_dark(row_dark);
  assign trail_fail = chk_trail && !all_dark(trail_view);
  assign gone_fail  = chk_gone  && (|row_dark);
  assign fail       = lead_fail || trail_fail || gone_fail;

  // R4/R5/R7: at most one check position is decoded at a time.
  always_comb begin
    a_one_check_r5: assert ($onehot0({chk_lead, chk_trail, chk_gone}));
  end
endmodule

// File: rtl/card_col_seq.sv
module card_col_seq
  import card_seq_pkg::*;
#(
  parameter int ROWS      = 12,
  parameter int DATA_COLS = 80,
  parameter int TICK_DIV  = 50000,
  parameter int SAMPLE_PH = TICK_DIV - TICK_DIV / 8,
  localparam int CW       = $clog2(DATA_COLS + 5)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_dark,
  input  logic            mask_notch,
  output logic [CW-1:0]   col_count,
  output logic            idx_strobe,
  output logic [ROWS-1:0] col_data,
  output logic            read_err,
  output logic            cycle_done
);
  localparam int TRAIL_COL = DATA_COLS + 1;
  localparam int END_COL   = DATA_COLS + 4;

  seq_state_t    state;
  logic [CW-1:0] col;
  logic          any_dark, start_ev, run, sample_pt, col_adv;
  logic          chk_lead, chk_trail, chk_gone, data_pt, check_fail;

  assign any_dark = |row_dark;
  assign start_ev = (state == ST_IDLE) && any_dark;
  assign run      = (state == ST_RUN);

  col_timer #(.TICK_DIV(TICK_DIV), .SAMPLE_PH(SAMPLE_PH)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_ev),
    .run      (run),
    .sample_pt(sample_pt),
    .col_adv  (col_adv)
  );

  assign chk_lead  = sample_pt && (col == '0);
  assign chk_trail = sample_pt && (col == CW'(TRAIL_COL));
  assign chk_gone  = sample_pt && (col == CW'(END_COL));
  assign data_pt   = sample_pt && is_data_col(int'(col), DATA_COLS);

  margin_check #(.ROWS(ROWS)) u_check (
    .row_dark (row_dark),
    .mask_top (mask_notch),
    .chk_lead (chk_lead),
    .chk_trail(chk_trail),
    .chk_gone (chk_gone),
    .fail     (check_fail)
  );

  // Card sequencing: idle -> run (85 columns) -> rearm until the path is clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      col   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ev) begin
          state <= ST_RUN;
          col   <= '0;
        end
        ST_RUN: begin
          if (col_adv && (col != CW'(END_COL))) col <= col + 1'b1;
          if (chk_gone) state <= ST_REARM;
        end
        ST_REARM: if (!any_dark) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_strobe <= 1'b0;
      col_data   <= '0;
      cycle_done <= 1'b0;
      read_err   <= 1'b0;
    end else begin
      idx_strobe <= data_pt;
      col_data   <= data_pt ? ~row_dark : '0;
      cycle_done <= chk_gone;
      if (start_ev)        read_err <= 1'b0;
      else if (check_fail) read_err <= 1'b1;
    end
  end

  assign col_count = col;

  // Record of the trailing check, for the once-per-card property.
  logic trail_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)         trail_seen <= 1'b0;
    else if (start_ev)  trail_seen <= 1'b0;
    else if (chk_trail) trail_seen <= 1'b1;
  end

  p_strobe_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_strobe |-> (col_count >= 1) && (col_count <= CW'(DATA_COLS)));
  p_trail_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_trail |-> !trail_seen);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_count <= CW'(END_COL));
  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (col_count == CW'(END_COL)) && !idx_strobe);
  p_rearm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REARM) && any_dark |=> (state == ST_REARM));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_err) |-> $past(start_ev));
  p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (col_count == '0) && !read_err);
endmodule

// File: tb/test_card_col_seq.sv
module test_card_col_seq;
  localparam int ROWS = 12, DC = 80, TD = 8, SP = 6, CW = 7;

  logic clk = 1'b0, rst_n = 1'b0, mask_notch = 1'b0;
  logic [ROWS-1:0] row_dark = '0;
  logic [CW-1:0] col_count;
  logic idx_strobe, read_err, cycle_done;
  logic [ROWS-1:0] col_data;

  always #5 clk = ~clk;

  card_col_seq #(.ROWS(ROWS), .DATA_COLS(DC), .TICK_DIV(TD), .SAMPLE_PH(SP)) i_card_col_seq (
    .clk(clk), .rst_n(rst_n), .row_dark(row_dark), .mask_notch(mask_notch),
    .col_count(col_count), .idx_strobe(idx_strobe), .col_data(col_data),
    .read_err(read_err), .cycle_done(cycle_done));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hole pattern for data column k of card with seed s (bit = 1 means punched).
  function automatic logic [11:0] holes(int k, int s);
    return 12'((k * 13 + s * 7) ^ (k << 4) ^ s);
  endfunction

  typedef struct packed {
    logic [7:0] seed;
    logic lead_bad, lead_notch, notch, mask, trail_bad, glitch, gone_bad, exp_err;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // clean
    '{8'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 lit at col 0
    '{8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 notch, no mask
    '{8'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 notch masked
    '{8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 mask spares row 12 only
    '{8'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 early leak ignored
    '{8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 still dark at col 84
    '{8'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R10 clears on next card
    '{8'd9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}   // R6 mask not at col 0
  };

  function automatic string tag_of(int i);
    case (i)
      1: return "R4";
      2: return "R5";
      3, 4, 8: return "R6";
      5: return "R8";
      6: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [11:0] pat(vec_t v, int k);
    logic [11:0] d;
    if (k == 0) begin
      d = '1;
      if (v.lead_bad) d[5] = 1'b0;
      if (v.lead_notch) d[11] = 1'b0;
    end else if (k <= DC) d = ~holes(k, int'(v.seed));
    else if (k == DC + 1) begin
      d = '1;
      if (v.notch) d[11] = 1'b0;
      if (v.trail_bad) d[2] = 1'b0;
    end else if (k == DC + 4) d = v.gone_bad ? '1 : '0;
    else d = '0;
    return d;
  endfunction

  // Monitor of the strobe stream, sampled away from the clock edge.
  int cur_seed = 0, str_cnt = 0, bad_data = 0, done_cnt = 0, exp_col = 1;
  always @(negedge clk) begin
    if (rst_n && idx_strobe) begin
      str_cnt++;
      if (int'(col_count) != exp_col || col_data != holes(int'(col_count), cur_seed)) bad_data++;
      exp_col++;
    end
    if (rst_n && cycle_done) done_cnt++;
  end

  task automatic run_card(input int idx);
    vec_t v = VEC[idx];
    cur_seed = int'(v.seed);
    str_cnt = 0; bad_data = 0; done_cnt = 0; exp_col = 1;
    mask_notch = v.mask;
    @(negedge clk) row_dark = pat(v, 0);
    @(posedge clk);
    @(negedge clk);
    chk(read_err == 1'b0 && col_count == 0, "R1 start", int'(read_err), 0);
    for (int k = 0; k <= DC + 4; k++) begin
      if (v.glitch && k == DC + 1) begin
        row_dark = pat(v, k) & ~12'h008;
        @(negedge clk);
        row_dark = pat(v, k);
        repeat (TD - 1) @(posedge clk);
      end else begin
        row_dark = pat(v, k);
        repeat (TD) @(posedge clk);
      end
      @(negedge clk);
      if (k == 0) chk(col_count == 1, "R2 first advance", int'(col_count), 1);
      if (k == DC + 3) chk(col_count == CW'(DC + 4), "R2 final column", int'(col_count), DC + 4);
    end
    chk(col_count == CW'(DC + 4), "R2 count stops", int'(col_count), DC + 4);
    chk(str_cnt == DC, "R3 strobe count", str_cnt, DC);
    chk(bad_data == 0, "R3 column data", bad_data, 0);
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(read_err == v.exp_err, tag_of(idx), int'(read_err), int'(v.exp_err));
    if (v.gone_bad) begin
      repeat (20) @(negedge clk);
      chk(read_err == 1'b1 && col_count == CW'(DC + 4), "R9 no restart while dark",
          int'(read_err), 1);
    end
    row_dark = '0;
    repeat (3) @(negedge clk);
    chk(read_err == v.exp_err, "R10 flag held", int'(read_err), int'(v.exp_err));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({col_count, idx_strobe, col_data, read_err, cycle_done} == '0, "R11 in reset", 1, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(col_count == 0 && str_cnt == 0 && done_cnt == 0, "R1 idle while lit",
        int'(col_count), 0);
    for (int i = 0; i < 9; i++) run_card(i);

    // Reset in mid-card.
    cur_seed = 1; mask_notch = 1'b0;
    row_dark = '1;
    repeat (TD * 10) @(negedge clk);
    rst_n = 1'b0; row_dark = '0;
    repeat (2) @(negedge clk);
    chk({col_count, idx_strobe, col_data, read_err, cycle_done} == '0, "R11 mid-card reset",
        int'(col_count), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(col_count == 0, "R11 stays idle", int'(col_count), 0);
    run_card(0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule